// File: doc/BRIEF.md
# Three-Step Sequence Lock Controller

This block is a clocked lock that opens only when three key values arrive in the right order. Each key entry is a value on a small bus together with a one-cycle strobe. A datapath keeps three stored code values. A one-hot select picks the code that applies to the current step, and an equality compare checks the entered value against it. A five-state controller moves through the three entry steps and then to an open state. Any wrong entry sends it to an error state.

The open output and the code select are taken straight from bits of the state register, so they need no output decoder. The open and error states stay put until a synchronous reset. Reset also restores the stored codes to their parameter defaults. Between resets, a write port can replace any one of the three codes.

Top module: `seq_lock_top`

## Requirements
- R1: A high `rst` at a rising edge puts the lock in the first entry step (`door_open`=0, `code_sel`=3'b001) on that edge, whatever the other inputs are.
- R2: In any of the three entry steps, an edge with `key_stb` low leaves `door_open` and `code_sel` unchanged.
- R3: An edge with `key_stb` high and `key_val` equal to the selected code advances the step. The select goes from 3'b001 (first code) to 3'b010 (second code), and from 3'b010 to 3'b100 (third code).
- R4: A matching entry while `code_sel`=3'b100 opens the lock: `door_open`=1 and `code_sel`=3'b000 from that edge on.
- R5: A strobed entry that differs from the selected code, at any of the three steps, enters the error state: `door_open`=0 and `code_sel`=3'b000.
- R6: Once the lock is open or in error, further strobed entries of any value leave both outputs unchanged until `rst`.
- R7: After reset, the first, second and third codes equal the parameters `CODE_A`, `CODE_B` and `CODE_C`, which default to 3, 4 and 2.
- R8: An edge with `code_wr` high and `code_slot` set to 0, 1 or 2 replaces the first, second or third code with `code_data`, taking effect from the next cycle. A write with `code_slot`=3 changes no code. Reset restores all three defaults.
- R9: `code_sel` is always one-hot or zero, and `door_open` is high only while `code_sel` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| key_val | input | CODE_W | Entered key value |
| key_stb | input | 1 | One-cycle strobe marking a new entry |
| code_wr | input | 1 | Write strobe for a stored code |
| code_slot | input | 2 | Index of the code to write (0..2) |
| code_data | input | CODE_W | New code value |
| door_open | output | 1 | 1 while open, 0 while closed |
| code_sel | output | 3 | One-hot select of the code being checked |

## Verification
Every result is due one edge after its stimulus. An entry strobe or reset seen at rising edge N shows on `door_open` and `code_sel` after edge N. A code write at edge N is used by the comparison at edge N+1 or later. The bench drives inputs on falling edges and updates a behavioural model at each rising edge. It compares both outputs 3 ns after every rising edge, so each result is checked in the cycle it becomes due and on every later cycle.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;
  // State encoding: bit 3 is the open output, bits 2:0 are the code select.
  typedef enum logic [3:0] {
    LK_ERR  = 4'b0000,
    LK_STEP1 = 4'b0001,
    LK_STEP2 = 4'b0010,
    LK_STEP3 = 4'b0100,
    LK_OPEN = 4'b1000
  } lock_state_t;

  localparam int unsigned NUM_CODES = 3;

  function automatic logic open_of(input lock_state_t s);
    return s[3];
  endfunction

  function automatic logic [NUM_CODES-1:0] sel_of(input lock_state_t s);
    return s[NUM_CODES-1:0];
  endfunction

  function automatic logic in_entry(input lock_state_t s);
    return (s == LK_STEP1) || (s == LK_STEP2) || (s == LK_STEP3);
  endfunction
endpackage

// File: rtl/seq_lock_codes.sv
module seq_lock_codes #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned NCODE  = 3,
  parameter logic [NCODE*CODE_W-1:0] INIT = '0,
  localparam int unsigned SLOT_W = $clog2(NCODE + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [CODE_W-1:0]       data,
  output logic [NCODE*CODE_W-1:0] codes
);
  for (genvar i = 0; i < NCODE; i++) begin : g_code
    logic [CODE_W-1:0] code_q;
    logic              hit;
    assign hit = wr && (slot == SLOT_W'(i));

    always_ff @(posedge clk) begin
      if (rst)      code_q <= INIT[i*CODE_W +: CODE_W];
      else if (hit) code_q <= data;
    end
    assign codes[i*CODE_W +: CODE_W] = code_q;

    p_write_r8: assert property (@(posedge clk) disable iff (rst)
      (wr && slot == SLOT_W'(i)) |=> codes[i*CODE_W +: CODE_W] == $past(data));
    p_keep_r8: assert property (@(posedge clk) disable iff (rst)
      !(wr && slot == SLOT_W'(i)) |=> $stable(codes[i*CODE_W +: CODE_W]));
  end
endmodule

// File: rtl/seq_lock_pick.sv
module seq_lock_pick #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned NCODE  = 3
) (
  input  logic [NCODE-1:0]        sel,
  input  logic [NCODE*CODE_W-1:0] codes,
  input  logic [CODE_W-1:0]       key,
  output logic                    match
);
  logic [CODE_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NCODE; i++)
      if (sel[i]) picked = picked | codes[i*CODE_W +: CODE_W];
  end

  assign match = (sel != '0) && (picked == key);
endmodule

// File: rtl/seq_lock_fsm.sv
module seq_lock_fsm
  import seq_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        stb,
  input  logic        match,
  output lock_state_t state
);
  lock_state_t nxt;
  logic entry_ok, entry_bad;

  assign entry_ok  = stb && match;
  assign entry_bad = stb && !match;

  always_comb begin
    nxt = state;
    if (in_entry(state) && entry_bad) nxt = LK_ERR;
    else if (entry_ok) begin
      unique case (state)
        LK_STEP1: nxt = LK_STEP2;
        LK_STEP2: nxt = LK_STEP3;
        LK_STEP3: nxt = LK_OPEN;
        default:  nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LK_STEP1;
    else     state <= nxt;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> state == LK_STEP1);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (in_entry(state) && !stb) |=> $stable(state));
  p_bad_r5: assert property (@(posedge clk) disable iff (rst)
    (in_entry(state) && entry_bad) |=> state == LK_ERR);
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (state == LK_OPEN || state == LK_ERR) |=> $stable(state));
  p_open_r4: assert property (@(posedge clk) disable iff (rst)
    (state == LK_STEP3 && entry_ok) |=> state == LK_OPEN);
endmodule

// File: rtl/seq_lock_top.sv
module seq_lock_top
  import seq_lock_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter logic [CODE_W-1:0] CODE_A = 4'd3,
  parameter logic [CODE_W-1:0] CODE_B = 4'd4,
  parameter logic [CODE_W-1:0] CODE_C = 4'd2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] key_val,
  input  logic              key_stb,
  input  logic              code_wr,
  input  logic [1:0]        code_slot,
  input  logic [CODE_W-1:0] code_data,
  output logic              door_open,
  output logic [2:0]        code_sel
);
  localparam logic [NUM_CODES*CODE_W-1:0] INIT_ALL = {CODE_C, CODE_B, CODE_A};

  logic [NUM_CODES*CODE_W-1:0] codes;
  logic                        key_match;
  lock_state_t                 state;

  seq_lock_codes #(.CODE_W(CODE_W), .NCODE(NUM_CODES), .INIT(INIT_ALL)) u_codes (
    .clk(clk), .rst(rst), .wr(code_wr), .slot(code_slot), .data(code_data), .codes(codes)
  );

  seq_lock_pick #(.CODE_W(CODE_W), .NCODE(NUM_CODES)) u_pick (
    .sel(code_sel), .codes(codes), .key(key_val), .match(key_match)
  );

  seq_lock_fsm u_fsm (
    .clk(clk), .rst(rst), .stb(key_stb), .match(key_match), .state(state)
  );

  assign door_open = open_of(state);
  assign code_sel  = sel_of(state);

  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (rst) $onehot0(code_sel));
  p_open_idle_sel_r9: assert property (@(posedge clk) disable iff (rst)
    door_open |-> code_sel == 3'b000);
  p_adv_r3: assert property (@(posedge clk) disable iff (rst)
    (key_stb && key_match && code_sel == 3'b001) |=> code_sel == 3'b010);
endmodule

// File: tb/tb_seq_lock_top.sv
module tb_seq_lock_top;
  logic clk = 0, rst = 1;
  logic [3:0] key_val = 0, code_data = 0;
  logic key_stb = 0, code_wr = 0;
  logic [1:0] code_slot = 0;
  logic door_open;
  logic [2:0] code_sel;

  int checks = 0, fails = 0;
  bit checking = 0, done = 0;
  string tag = "R1";

  // behavioural model: stage 0..2 entry, 3 open, 4 error
  int m_stage = 0;
  int m_code[3] = '{3, 4, 2};

  always #5 clk = ~clk;

  seq_lock_top dut (.clk(clk), .rst(rst), .key_val(key_val), .key_stb(key_stb),
    .code_wr(code_wr), .code_slot(code_slot), .code_data(code_data),
    .door_open(door_open), .code_sel(code_sel));

  always @(posedge clk) begin
    if (rst) begin
      m_stage = 0;
      m_code = '{3, 4, 2};
    end else begin
      if (key_stb && m_stage < 3)
        m_stage = (int'(key_val) == m_code[m_stage]) ? m_stage + 1 : 4;
      if (code_wr && code_slot < 3) m_code[code_slot] = int'(code_data);
    end
  end

  task automatic check(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", t, act, exp, $time);
    end
  endtask

  function automatic int exp_sel(input int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 0;
  endfunction

  // per-cycle compare against the model (R9 on every cycle, plus current scenario tag)
  always @(posedge clk) begin
    #3;
    if (checking && !done) begin
      check(door_open === (m_stage == 3), {tag, " open"}, int'(door_open), int'(m_stage == 3));
      check(code_sel === 3'(exp_sel(m_stage)), {tag, " sel"}, int'(code_sel), exp_sel(m_stage));
      check(!(door_open && code_sel != 0), "R9 open-with-sel", int'(code_sel), 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic key(input int v);
    @(negedge clk); key_val = 4'(v); key_stb = 1;
    @(negedge clk); key_stb = 0;
  endtask

  task automatic wr(input int s, input int d);
    @(negedge clk); code_slot = 2'(s); code_data = 4'(d); code_wr = 1;
    @(negedge clk); code_wr = 0;
  endtask

  task automatic do_reset(input bit with_stb);
    @(negedge clk); rst = 1; key_stb = with_stb; key_val = 4'd3;
    @(negedge clk); rst = 0; key_stb = 0;
  endtask

  task automatic expect_out(input bit op, input int sel, input string t);
    check(door_open === op, t, int'(door_open), int'(op));
    check(code_sel === 3'(sel), t, int'(code_sel), sel);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); @(negedge clk);
    checking = 1;
    rst = 0;
    tag = "R1"; expect_out(0, 1, "R1 reset state");
    // R2 R3 R4 R7: correct default sequence with idle gaps
    tag = "R2"; idle(3); expect_out(0, 1, "R2 idle hold");
    tag = "R3"; key(3); expect_out(0, 2, "R3 step to second");
    idle(2); key(4); expect_out(0, 4, "R3 step to third");
    tag = "R4"; idle(1); key(2); expect_out(1, 0, "R4 open R7 defaults");
    // R6: extra entries after open
    tag = "R6"; key(2); key(7); idle(2); expect_out(1, 0, "R6 open sticky");
    // R5: wrong at each position
    tag = "R5";
    do_reset(0); key(5); expect_out(0, 0, "R5 bad first");
    tag = "R6"; key(3); key(4); key(2); expect_out(0, 0, "R6 error sticky");
    tag = "R5";
    do_reset(0); key(3); key(9); expect_out(0, 0, "R5 bad second");
    do_reset(0); key(3); key(4); key(3); expect_out(0, 0, "R5 bad third");
    // R1: reset mid-sequence, strobe during reset ignored
    tag = "R1";
    do_reset(0); key(3); key(4); do_reset(1); expect_out(0, 1, "R1 reset mid-sequence");
    key(3); key(4); key(2); expect_out(1, 0, "R1 full sequence after reset");
    // R8: code write, slot 3 ignored, reset restores
    tag = "R8";
    do_reset(0); wr(1, 9); wr(3, 7); key(3); key(9); key(2);
    expect_out(1, 0, "R8 written second code");
    do_reset(0); key(3); key(9); expect_out(0, 0, "R8 reset restores default");
    do_reset(0); wr(0, 15); wr(2, 0); key(15); key(4); key(0);
    expect_out(1, 0, "R8 first and third written");
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule